// File: doc/BRIEF.md
# Microcoded Datapath ALU with Output Shifter

This block is the arithmetic stage of a three-bus microcoded datapath. One operand is always the holding register, brought in on `h_in`. The other operand is whichever register the surrounding decode has placed on the B bus, brought in on `b_raw`. A small width-conditioning stage sits in front of the B operand. It lets a byte-wide source enter either sign-extended or zero-extended. A six-bit function word from the microinstruction picks the operation. It has two function-select bits, an enable for each operand, an invert for the A operand and a carry-in bit.

The ALU result passes through a shifter before it leaves on the C bus. A two-bit shift word selects no shift, a logical shift left by one byte, or an arithmetic shift right by one. Negative and zero status flags come from the ALU result before it is shifted. The microsequencer uses them for conditional branches. The block is purely combinational. The register file, the bus-enable decode and the sequencer sit outside it.

Top module: `uc_alu_shifter`

## Requirements
- R1: When `alu_ctl[3]` (A enable) is 0, the A operand is zero. When `alu_ctl[2]` (B enable) is 0, the B operand is zero.
- R2: When `alu_ctl[1]` (A invert) is 1, the A operand is bitwise inverted after the enable gating. A disabled, inverted A is therefore all ones.
- R3: `alu_ctl[5:4]` selects the function: 00 is A AND B, 01 is A OR B, 10 is NOT B, 11 is ADD.
- R4: ADD yields A + B + `alu_ctl[0]` (carry-in), modulo 2^32. The carry out is discarded.
- R5: The carry-in bit `alu_ctl[0]` has no effect on the AND, OR and NOT B functions.
- R6: `shift_ctl` = 10 shifts the ALU result left by 8 bits and fills the low bits with zeros.
- R7: `shift_ctl` = 01 shifts the ALU result right by 1 bit and copies the old bit 31 into bit 31.
- R8: `shift_ctl` = 00 passes the ALU result unshifted. The illegal code 11 also passes it unshifted.
- R9: `n_flag` is bit 31 of the unshifted ALU result. `z_flag` is 1 exactly when the unshifted ALU result is zero. Neither flag depends on `shift_ctl`.
- R10: `b_ext_sel` = 01 copies `b_raw[7]` into B bits 31:8. `b_ext_sel` = 10 fills B bits 31:8 with zeros. Codes 00 and 11 pass `b_raw` unchanged. Bits 7:0 always come from `b_raw`.
- R11: The function words give the named operations: 0x3F gives B−A, 0x3B gives −A, 0x36 gives B−1, 0x32 gives −1, 0x31 gives constant 1, and 0x00 gives constant 0.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_in | input | 32 | Holding register value, the A operand |
| b_raw | input | 32 | Value on the B bus before width conditioning |
| b_ext_sel | input | 2 | B conditioning: 00 pass, 01 sign-extend byte, 10 zero-extend byte, 11 pass |
| alu_ctl | input | 6 | {fn[1:0], A enable, B enable, A invert, carry-in} |
| shift_ctl | input | 2 | {shift left 8, arithmetic shift right 1} |
| c_bus | output | 32 | Shifted result driven onto the C bus |
| n_flag | output | 1 | Bit 31 of the unshifted ALU result |
| z_flag | output | 1 | Unshifted ALU result is zero |

## Verification
Directed vectors drive each named microinstruction code with operand values whose results differ between plausible mistakes. Examples are B−A against A−B, and a sum that wraps past 2^32. They also drive a byte-sized B source with bit 7 set under each conditioning code. Shift checks use values with both the top and bottom bits set, so that a logical right shift cannot pass for an arithmetic one. Other pairs are chosen so that the shifted and unshifted results disagree in sign or zeroness, which shows where the flags are taken. Several thousand seeded random combinations of all control fields and operands are then compared against a bench model, including the illegal shift code and the reserved conditioning code.

// File: rtl/ucalu_pkg.sv
package ucalu_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    BX_PASS = 2'b00,
    BX_SEXT = 2'b01,
    BX_ZEXT = 2'b10,
    BX_RSVD = 2'b11
  } bext_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_SRA1 = 2'b01,
    SH_SLL  = 2'b10,
    SH_BAD  = 2'b11
  } shift_e;

  typedef struct packed {
    logic [1:0] fn;
    logic       ena;
    logic       enb;
    logic       inva;
    logic       cin;
  } alu_ctl_t;

endpackage

// File: rtl/ucalu_bext.sv
module ucalu_bext
  import ucalu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int EXT_BITS = 8
) (
  input  logic [WIDTH-1:0] raw,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] b_out
);

  localparam int HI_BITS = WIDTH - EXT_BITS;

  logic [EXT_BITS-1:0] low_part;
  logic [HI_BITS-1:0]  hi_part;

  assign low_part = raw[EXT_BITS-1:0];
  assign hi_part  = raw[WIDTH-1:EXT_BITS];

  always_comb begin
    case (bext_e'(sel))
      BX_SEXT: b_out = {{HI_BITS{low_part[EXT_BITS-1]}}, low_part};
      BX_ZEXT: b_out = {{HI_BITS{1'b0}}, low_part};
      default: b_out = {hi_part, low_part};
    endcase
  end

endmodule

// File: rtl/ucalu_core.sv
module ucalu_core
  import ucalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_src,
  input  logic [WIDTH-1:0] b_src,
  input  alu_ctl_t         ctl,
  output logic [WIDTH-1:0] result,
  output logic             neg,
  output logic             zero
);

  logic [WIDTH-1:0] a_gated;
  logic [WIDTH-1:0] a_op;
  logic [WIDTH-1:0] b_op;
  logic [WIDTH-1:0] sum;

  assign a_gated = ctl.ena ? a_src : '0;
  assign a_op    = ctl.inva ? ~a_gated : a_gated;
  assign b_op    = ctl.enb ? b_src : '0;
  assign sum     = a_op + b_op + WIDTH'(ctl.cin);

  always_comb begin
    case (alu_fn_e'(ctl.fn))
      FN_AND:  result = a_op & b_op;
      FN_OR:   result = a_op | b_op;
      FN_NOTB: result = ~b_op;
      default: result = sum;
    endcase
  end

  assign neg  = result[WIDTH-1];
  assign zero = (result == '0);

endmodule

// File: rtl/ucalu_shift.sv
module ucalu_shift
  import ucalu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int SHL_AMT = 8
) (
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] left_v;
  logic [WIDTH-1:0] right_v;

  assign left_v  = {din[WIDTH-1-SHL_AMT:0], {SHL_AMT{1'b0}}};
  assign right_v = {din[WIDTH-1], din[WIDTH-1:1]};

  always_comb begin
    case (shift_e'(mode))
      SH_SLL:  dout = left_v;
      SH_SRA1: dout = right_v;
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/uc_alu_shifter.sv
module uc_alu_shifter
  import ucalu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int EXT_BITS = 8,
  parameter int SHL_AMT  = 8
) (
  input  logic [WIDTH-1:0] h_in,
  input  logic [WIDTH-1:0] b_raw,
  input  logic [1:0]       b_ext_sel,
  input  logic [5:0]       alu_ctl,
  input  logic [1:0]       shift_ctl,
  output logic [WIDTH-1:0] c_bus,
  output logic             n_flag,
  output logic             z_flag
);

  logic [WIDTH-1:0] b_cond;
  logic [WIDTH-1:0] alu_res;
  alu_ctl_t         ctl_s;

  assign ctl_s = alu_ctl_t'(alu_ctl);

  ucalu_bext #(.WIDTH(WIDTH), .EXT_BITS(EXT_BITS)) u_bext (
    .raw   (b_raw),
    .sel   (b_ext_sel),
    .b_out (b_cond)
  );

  ucalu_core #(.WIDTH(WIDTH)) u_core (
    .a_src  (h_in),
    .b_src  (b_cond),
    .ctl    (ctl_s),
    .result (alu_res),
    .neg    (n_flag),
    .zero   (z_flag)
  );

  ucalu_shift #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_shift (
    .din  (alu_res),
    .mode (shift_ctl),
    .dout (c_bus)
  );

endmodule

// File: rtl/uc_alu_shifter_chk.sv
module uc_alu_shifter_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] h_in,
  input logic [WIDTH-1:0] b_raw,
  input logic [1:0]       b_ext_sel,
  input logic [5:0]       alu_ctl,
  input logic [1:0]       shift_ctl,
  input logic [WIDTH-1:0] c_bus,
  input logic             n_flag,
  input logic             z_flag
);

  always_comb begin
    if (shift_ctl == 2'b00 || shift_ctl == 2'b11) begin
      AST_N_UNSHIFTED: assert (n_flag == c_bus[WIDTH-1]) else $error("n flag mismatch"); // R9
      AST_Z_UNSHIFTED: assert (z_flag == (c_bus == '0)) else $error("z flag mismatch"); // R8
    end
    if (shift_ctl == 2'b01) begin
      AST_SRA_SIGN: assert (c_bus[WIDTH-1] == c_bus[WIDTH-2] && c_bus[WIDTH-1] == n_flag)
        else $error("sign not replicated"); // R7
    end
    if (shift_ctl == 2'b10) begin
      AST_SLL_FILL: assert (c_bus[7:0] == 8'h00) else $error("left shift fill"); // R6
    end
    if (alu_ctl == 6'h00) begin
      AST_CONST_ZERO: assert (z_flag && !n_flag && c_bus == '0) else $error("const zero"); // R11
    end
    if (alu_ctl == 6'b001100 && shift_ctl == 2'b00 && b_ext_sel == 2'b00) begin
      AST_AND_FN: assert (c_bus == (h_in & b_raw)) else $error("and function"); // R3
    end
  end

endmodule

bind uc_alu_shifter uc_alu_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .h_in      (h_in),
  .b_raw     (b_raw),
  .b_ext_sel (b_ext_sel),
  .alu_ctl   (alu_ctl),
  .shift_ctl (shift_ctl),
  .c_bus     (c_bus),
  .n_flag    (n_flag),
  .z_flag    (z_flag)
);

// File: tb/uc_alu_shifter_tb.sv
module uc_alu_shifter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic [W-1:0] h_in, b_raw;
  logic [1:0]   b_ext_sel, shift_ctl;
  logic [5:0]   alu_ctl;
  logic [W-1:0] c_bus;
  logic         n_flag, z_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  uc_alu_shifter u_dut (
    .h_in(h_in), .b_raw(b_raw), .b_ext_sel(b_ext_sel), .alu_ctl(alu_ctl),
    .shift_ctl(shift_ctl), .c_bus(c_bus), .n_flag(n_flag), .z_flag(z_flag)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected {n, z, c} from the requirement text.
  function automatic logic [W+1:0] model(input logic [W-1:0] h, input logic [W-1:0] br,
                                         input logic [1:0] bx, input logic [5:0] ctl,
                                         input logic [1:0] sh);
    logic [W-1:0] bv, av, bo, r, o;
    case (bx)
      2'b01:   bv = {{24{br[7]}}, br[7:0]};
      2'b10:   bv = {24'h0, br[7:0]};
      default: bv = br;
    endcase
    av = ctl[3] ? h : 32'h0;
    if (ctl[1]) av = ~av;
    bo = ctl[2] ? bv : 32'h0;
    case (ctl[5:4])
      2'b00:   r = av & bo;
      2'b01:   r = av | bo;
      2'b10:   r = ~bo;
      default: r = av + bo + {31'h0, ctl[0]};
    endcase
    case (sh)
      2'b10:   o = r << 8;
      2'b01:   o = {r[31], r[31:1]};
      default: o = r;
    endcase
    return {r[31], (r == 32'h0), o};
  endfunction

  task automatic run(input string tag, input logic [W-1:0] h, input logic [W-1:0] br,
                     input logic [1:0] bx, input logic [5:0] ctl, input logic [1:0] sh);
    logic [W+1:0] exp_v;
    @(posedge clk);
    h_in = h; b_raw = br; b_ext_sel = bx; alu_ctl = ctl; shift_ctl = sh;
    @(negedge clk);
    exp_v = model(h, br, bx, ctl, sh);
    checks++;
    if ({n_flag, z_flag, c_bus} !== exp_v) begin
      failures++;
      $display("FAIL %s: actual n=%0b z=%0b c=%08h expected n=%0b z=%0b c=%08h",
               tag, n_flag, z_flag, c_bus, exp_v[W+1], exp_v[W], exp_v[W-1:0]);
    end
  endtask

  task automatic expect_c(input string tag, input logic [W-1:0] expv);
    checks++;
    if (c_bus !== expv) begin
      failures++;
      $display("FAIL %s: actual c=%08h expected c=%08h", tag, c_bus, expv);
    end
  endtask

  initial begin
    h_in = '0; b_raw = '0; b_ext_sel = '0; alu_ctl = '0; shift_ctl = '0;
    void'($urandom(32'd2024));
    // idle: all zero inputs give constant 0
    run("R11 idle zero", 32'h0, 32'h0, 2'b00, 6'h00, 2'b00);
    expect_c("R11 idle zero", 32'h0);
    // R1 gating
    run("R1 A disabled", 32'h1234, 32'h5, 2'b00, 6'b110100, 2'b00);
    expect_c("R1 A disabled", 32'h5);
    run("R1 B disabled", 32'h1234, 32'h5, 2'b00, 6'b111000, 2'b00);
    expect_c("R1 B disabled", 32'h1234);
    // R2 invert
    run("R2 NOT A", 32'hF0F0_0000, 32'h77, 2'b00, 6'b011010, 2'b00);
    expect_c("R2 NOT A", 32'h0F0F_FFFF);
    // R3 logic
    run("R3 AND", 32'hFF00_FF00, 32'h0FF0_0FF0, 2'b00, 6'b001100, 2'b00);
    expect_c("R3 AND", 32'h0F00_0F00);
    run("R3 OR", 32'hFF00_0000, 32'h0000_00FF, 2'b00, 6'b011100, 2'b00);
    expect_c("R3 OR", 32'hFF00_00FF);
    run("R3 NOT B", 32'h1, 32'h0000_FFFF, 2'b00, 6'b101100, 2'b00);
    expect_c("R3 NOT B", 32'hFFFF_0000);
    // R4 add wrap
    run("R4 wrap", 32'hFFFF_FFFF, 32'h1, 2'b00, 6'b111100, 2'b00);
    expect_c("R4 wrap", 32'h0);
    run("R4 A+B+1", 32'h10, 32'h20, 2'b00, 6'b111101, 2'b00);
    expect_c("R4 A+B+1", 32'h31);
    // R5 carry ignored for logic
    run("R5 AND cin", 32'hF0, 32'h3C, 2'b00, 6'b001101, 2'b00);
    expect_c("R5 AND cin", 32'h30);
    run("R5 NOTB cin", 32'h0, 32'hFFFF_FFFF, 2'b00, 6'b100101, 2'b00);
    expect_c("R5 NOTB cin", 32'h0);
    // R6 / R7 / R8 shifts
    run("R6 SLL8", 32'h0, 32'h1234_5678, 2'b00, 6'b110100, 2'b10);
    expect_c("R6 SLL8", 32'h3456_7800);
    run("R7 SRA1 neg", 32'h0, 32'h8000_0011, 2'b00, 6'b110100, 2'b01);
    expect_c("R7 SRA1 neg", 32'hC000_0008);
    run("R7 SRA1 pos", 32'h0, 32'h4000_0003, 2'b00, 6'b110100, 2'b01);
    expect_c("R7 SRA1 pos", 32'h2000_0001);
    run("R8 illegal code", 32'h0, 32'h8000_0081, 2'b00, 6'b110100, 2'b11);
    expect_c("R8 illegal code", 32'h8000_0081);
    // R9 flags pre-shift
    run("R9 N pre-shift", 32'h0, 32'h0080_0000, 2'b00, 6'b110100, 2'b10);
    checks++;
    if (n_flag !== 1'b0 || z_flag !== 1'b0) begin
      failures++; $display("FAIL R9: actual n=%0b z=%0b expected n=0 z=0", n_flag, z_flag);
    end
    run("R9 Z pre-shift", 32'h0, 32'h1, 2'b00, 6'b110100, 2'b01);
    checks++;
    if (z_flag !== 1'b0 || c_bus !== 32'h0) begin
      failures++; $display("FAIL R9: actual z=%0b c=%08h expected z=0 c=0", z_flag, c_bus);
    end
    // R10 B conditioning
    run("R10 sext", 32'h0, 32'hABCD_12F5, 2'b01, 6'b110100, 2'b00);
    expect_c("R10 sext", 32'hFFFF_FFF5);
    run("R10 zext", 32'h0, 32'hABCD_12F5, 2'b10, 6'b110100, 2'b00);
    expect_c("R10 zext", 32'h0000_00F5);
    run("R10 pass", 32'h0, 32'hABCD_12F5, 2'b00, 6'b110100, 2'b00);
    expect_c("R10 pass", 32'hABCD_12F5);
    run("R10 reserved", 32'h0, 32'hABCD_12F5, 2'b11, 6'b110100, 2'b00);
    expect_c("R10 reserved", 32'hABCD_12F5);
    run("R10 sext pos", 32'h0, 32'hFFFF_FF75, 2'b01, 6'b110100, 2'b00);
    expect_c("R10 sext pos", 32'h0000_0075);
    // R11 named ops
    run("R11 B-A", 32'h3, 32'hA, 2'b00, 6'h3F, 2'b00);
    expect_c("R11 B-A", 32'h7);
    run("R11 -A", 32'h5, 32'h9, 2'b00, 6'h3B, 2'b00);
    expect_c("R11 -A", 32'hFFFF_FFFB);
    run("R11 B-1", 32'h5, 32'h9, 2'b00, 6'h36, 2'b00);
    expect_c("R11 B-1", 32'h8);
    run("R11 -1", 32'h5, 32'h9, 2'b00, 6'h32, 2'b00);
    expect_c("R11 -1", 32'hFFFF_FFFF);
    run("R11 one", 32'h5, 32'h9, 2'b00, 6'h31, 2'b00);
    expect_c("R11 one", 32'h1);
    // random sweep across all fields (R3 R4 R6 R7 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] rh, rb;
      rh = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = 32'h0;
      if (i % 11 == 0) rh = 32'hFFFF_FFFF;
      run("R12 random", rh, rb, 2'($urandom), 6'($urandom), 2'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule